// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides which operating mode a CAN controller is in: sleep, initialization, normal or bus-off. Software drives request and option bits from its control register. The block turns them into mode changes, and it holds back any change that would cut a frame in progress. It watches the sampled receive bit, which arrives with a one-cycle bit-time strobe. It counts runs of recessive bits so that it only joins the bus once the bus is idle. It also looks for a recessive-to-dominant edge, which it treats as a start of frame and uses for automatic wakeup.

The block reports its state in three ways: a one-hot mode vector, an init acknowledge flag and a sleep acknowledge flag. It keeps a sticky wakeup flag, which software clears by writing 1, and it gives a one-cycle status interrupt pulse when that flag rises. The control register that holds the sleep request must clear that bit whenever the block pulses its hardware-clear output. Entry into bus-off comes from the error logic as a one-cycle pulse. Leaving bus-off is either automatic, after enough recessive runs, or done by software.

Top module: `can_mode_seq`

## Requirements
- R1: Reset is synchronous and active high. After reset the mode is sleep, slak is 1, inak is 0, and wkui, status_irq and sleep_hw_clr are 0.
- R2: `mode` is always one-hot, with these bits: bit 0 sleep, bit 1 initialization, bit 2 normal, bit 3 bus-off. `inak` is 1 exactly in initialization mode and `slak` is 1 exactly in sleep mode.
- R3: In normal mode, an init request waits while `bus_busy` is 1 and `frame_done` is 0. It is taken on the first clock edge where the bus is idle or `frame_done` is 1.
- R4: With the init request low in initialization mode, the block counts recessive samples taken on strobe cycles. A dominant sample restarts the count. The mode turns normal on the clock edge that follows the edge on which the 11th consecutive recessive sample was taken.
- R5: In normal mode with automatic wakeup off, a sleep request waits for the bus to go idle or for `frame_done`, and then enters sleep. A sleep request made in initialization mode is taken on the next edge.
- R6: In sleep mode, dropping the sleep request moves the block to initialization mode, and the synchronisation rule of R4 then applies.
- R7: In sleep mode with automatic wakeup on, a strobe sample of 0 whose previous strobe sample was 1 has three effects on the next edge: the mode becomes initialization, `sleep_hw_clr` pulses and `wkui` is set.
- R8: In normal mode with automatic wakeup on, a sleep request while `bus_busy` is 1 is refused. The mode stays normal, `sleep_hw_clr` pulses and `wkui` is set.
- R9: Once set, `wkui` stays 1 until a cycle with `wkui_clr` at 1 and no new wakeup event. It then reads 0 after that edge.
- R10: `status_irq` is high for exactly the cycle in which `wkui` goes from 0 to 1.
- R11: `busoff_enter` in normal mode gives bus-off on the next edge. With automatic bus-off exit on, the block returns to normal one edge after it has counted 128 separate runs of 11 recessive samples. The run counters start from zero at entry.
- R12: With automatic bus-off exit off, bus-off is held no matter how much recessive traffic arrives, until the init request is set. The mode then becomes initialization on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_init | input | 1 | Software initialization request |
| req_sleep | input | 1 | Software sleep request |
| auto_wake_en | input | 1 | Enable wakeup on start of frame |
| auto_busoff_en | input | 1 | Enable automatic bus-off exit |
| wkui_clr | input | 1 | Software write-1 clear of wkui |
| rx_bit | input | 1 | Sampled receive bit (1 = recessive) |
| bit_stb | input | 1 | One-cycle bit-time strobe qualifying rx_bit |
| bus_busy | input | 1 | A frame is being sent or received |
| frame_done | input | 1 | Current frame finishes this cycle |
| busoff_enter | input | 1 | Pulse: error logic enters bus-off |
| mode | output | 4 | One-hot mode: sleep, init, normal, bus-off |
| inak | output | 1 | Initialization acknowledge |
| slak | output | 1 | Sleep acknowledge |
| wkui | output | 1 | Sticky wakeup flag |
| status_irq | output | 1 | Pulse on wkui rising |
| sleep_hw_clr | output | 1 | Pulse telling the register to clear the sleep request |

## Verification
A behavioural model in the bench steps along with the design and is compared every cycle. The stimulus for synchronisation is recessive runs broken by one dominant bit, which shows whether the counter restarts or only pauses. Requests are made both while the bus is busy and at the moment `frame_done` arrives, which tests deferral against immediate action. Sleep requests are made with automatic wakeup on and off, and a start of frame is sent while asleep, which tests the refuse and wake paths. In bus-off, a long recessive stream is sent with automatic exit on and then off. This shows whether the 128-run count is honoured or the mode is held.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [3:0] {
        M_SLEEP  = 4'b0001,
        M_INIT   = 4'b0010,
        M_NORMAL = 4'b0100,
        M_BUSOFF = 4'b1000
    } mode_e;

    typedef struct packed {
        logic init;
        logic sleep;
        logic auto_wake;
        logic auto_busoff;
    } req_t;

    // recessive-to-dominant transition on a strobed sample
    function automatic logic sof_seen(input logic stb, input logic prev, input logic cur);
        return stb & prev & ~cur;
    endfunction

endpackage

// File: rtl/can_run_counter.sv
module can_run_counter #(
    parameter int RUN_LEN     = 11,
    parameter int BUSOFF_RUNS = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic rx_bit,
    input  logic sync_en,
    input  logic wrap_en,
    output logic run_done,
    output logic runs_done
);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam int NW = $clog2(BUSOFF_RUNS + 1);

    logic [RW-1:0] run_q;
    logic [NW-1:0] runs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            runs_q <= '0;
        end else begin
            if (!wrap_en) runs_q <= '0;
            if (!sync_en && !wrap_en) begin
                run_q <= '0;
            end else if (bit_stb) begin
                if (!rx_bit) begin
                    run_q <= '0;
                end else if (sync_en) begin
                    if (run_q != RW'(RUN_LEN)) run_q <= run_q + 1'b1;
                end else if (run_q == RW'(RUN_LEN - 1)) begin
                    run_q <= '0;
                    if (runs_q != NW'(BUSOFF_RUNS)) runs_q <= runs_q + 1'b1;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    assign run_done  = sync_en && (run_q == RW'(RUN_LEN));
    assign runs_done = wrap_en && (runs_q == NW'(BUSOFF_RUNS));

    // R4: a dominant sample restarts the recessive run
    a_r4_dominant_restart: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !rx_bit && (sync_en || wrap_en)) |=> (run_q == '0));

    // R11: the run tally never passes its limit
    a_r11_runs_bounded: assert property (@(posedge clk) disable iff (rst)
        runs_q <= NW'(BUSOFF_RUNS));

    // R11: tally is zero whenever bus-off counting is not active
    a_r11_runs_clear: assert property (@(posedge clk) disable iff (rst)
        !wrap_en |=> (!$past(wrap_en) -> runs_q == '0));

endmodule

// File: rtl/can_wake_flags.sv
module can_wake_flags (
    input  logic clk,
    input  logic rst,
    input  logic wake_evt,
    input  logic refuse_evt,
    input  logic wkui_clr,
    output logic wkui,
    output logic status_irq,
    output logic sleep_hw_clr
);
    logic wkui_q, irq_q, clr_q, set_now;

    assign set_now = wake_evt | refuse_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wkui_q <= 1'b0;
            irq_q  <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            if (set_now)       wkui_q <= 1'b1;
            else if (wkui_clr) wkui_q <= 1'b0;
            irq_q <= set_now & ~wkui_q;
            clr_q <= set_now;
        end
    end

    assign wkui         = wkui_q;
    assign status_irq   = irq_q;
    assign sleep_hw_clr = clr_q;

    // R9: the flag is sticky without a software clear
    a_r9_wkui_sticky: assert property (@(posedge clk) disable iff (rst)
        (wkui_q && !wkui_clr) |=> wkui_q);

    // R10: interrupt accompanies every rise of the flag
    a_r10_irq_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(wkui_q) |-> irq_q);

    // R10: interrupt only when the flag has just risen
    a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (wkui_q && !$past(wkui_q)));

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  req_t  req,
    input  logic  rx_bit,
    input  logic  bit_stb,
    input  logic  bus_busy,
    input  logic  frame_done,
    input  logic  busoff_enter,
    input  logic  sleep_hw_clr,
    input  logic  run_done,
    input  logic  runs_done,
    output mode_e mode,
    output logic  sync_en,
    output logic  wrap_en,
    output logic  wake_evt,
    output logic  refuse_evt
);
    mode_e mode_q, mode_d;
    logic  rx_prev_q;
    logic  sof, act_done, sleep_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= M_SLEEP;
            rx_prev_q <= 1'b1;
        end else begin
            mode_q <= mode_d;
            if (bit_stb) rx_prev_q <= rx_bit;
        end
    end

    assign sof      = sof_seen(bit_stb, rx_prev_q, rx_bit);
    assign act_done = ~bus_busy | frame_done;
    assign sleep_ok = req.sleep & ~sleep_hw_clr;

    always_comb begin
        mode_d     = mode_q;
        wake_evt   = 1'b0;
        refuse_evt = 1'b0;
        unique case (mode_q)
            M_SLEEP: begin
                if (req.auto_wake && sof) begin
                    mode_d   = M_INIT;
                    wake_evt = 1'b1;
                end else if (!req.sleep) begin
                    mode_d = M_INIT;
                end
            end
            M_INIT: begin
                if (sleep_ok)                   mode_d = M_SLEEP;
                else if (!req.init && run_done) mode_d = M_NORMAL;
            end
            M_NORMAL: begin
                if (busoff_enter) begin
                    mode_d = M_BUSOFF;
                end else if (req.init && act_done) begin
                    mode_d = M_INIT;
                end else if (sleep_ok) begin
                    if (req.auto_wake && bus_busy) refuse_evt = 1'b1;
                    else if (act_done)             mode_d = M_SLEEP;
                end
            end
            M_BUSOFF: begin
                if (req.init)                             mode_d = M_INIT;
                else if (req.auto_busoff && runs_done)    mode_d = M_NORMAL;
            end
            default: mode_d = M_SLEEP;
        endcase
    end

    assign mode    = mode_q;
    assign sync_en = (mode_q == M_INIT) && !req.init;
    assign wrap_en = (mode_q == M_BUSOFF);

    // R2: exactly one mode at a time
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(mode_q) == 1);

    // R3: no mode change out of normal while a frame is still on the bus
    a_r3_defer: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_NORMAL && bus_busy && !frame_done && !busoff_enter) |=> (mode_q == M_NORMAL));

    // R4: normal is never reached from init before the recessive run completes
    a_r4_sync_gate: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_INIT && !run_done) |=> (mode_q != M_NORMAL));

    // R7: start of frame in sleep with automatic wakeup leaves sleep
    a_r7_wake: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_SLEEP && req.auto_wake && sof) |=> (mode_q == M_INIT));

    // R12: bus-off held without automatic exit or init request
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_BUSOFF && !req.init && !req.auto_busoff) |=> (mode_q == M_BUSOFF));

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int RUN_LEN     = 11,
    parameter int BUSOFF_RUNS = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_init,
    input  logic       req_sleep,
    input  logic       auto_wake_en,
    input  logic       auto_busoff_en,
    input  logic       wkui_clr,
    input  logic       rx_bit,
    input  logic       bit_stb,
    input  logic       bus_busy,
    input  logic       frame_done,
    input  logic       busoff_enter,
    output logic [3:0] mode,
    output logic       inak,
    output logic       slak,
    output logic       wkui,
    output logic       status_irq,
    output logic       sleep_hw_clr
);
    req_t  req;
    mode_e mode_w;
    logic  sync_en, wrap_en, run_done, runs_done, wake_evt, refuse_evt;

    assign req = '{init: req_init, sleep: req_sleep,
                   auto_wake: auto_wake_en, auto_busoff: auto_busoff_en};

    can_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .rx_bit       (rx_bit),
        .bit_stb      (bit_stb),
        .bus_busy     (bus_busy),
        .frame_done   (frame_done),
        .busoff_enter (busoff_enter),
        .sleep_hw_clr (sleep_hw_clr),
        .run_done     (run_done),
        .runs_done    (runs_done),
        .mode         (mode_w),
        .sync_en      (sync_en),
        .wrap_en      (wrap_en),
        .wake_evt     (wake_evt),
        .refuse_evt   (refuse_evt)
    );

    can_run_counter #(.RUN_LEN(RUN_LEN), .BUSOFF_RUNS(BUSOFF_RUNS)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .rx_bit    (rx_bit),
        .sync_en   (sync_en),
        .wrap_en   (wrap_en),
        .run_done  (run_done),
        .runs_done (runs_done)
    );

    can_wake_flags u_flags (
        .clk          (clk),
        .rst          (rst),
        .wake_evt     (wake_evt),
        .refuse_evt   (refuse_evt),
        .wkui_clr     (wkui_clr),
        .wkui         (wkui),
        .status_irq   (status_irq),
        .sleep_hw_clr (sleep_hw_clr)
    );

    assign mode = mode_w;
    assign inak = (mode_w == M_INIT);
    assign slak = (mode_w == M_SLEEP);

    // R8: a refused sleep never leaves normal mode
    a_r8_refuse_stays: assert property (@(posedge clk) disable iff (rst)
        refuse_evt |=> (mode == 4'b0100));

    // R11: bus-off entry from normal is immediate
    a_r11_enter: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'b0100 && busoff_enter) |=> (mode == 4'b1000));

endmodule

// File: tb/can_mode_seq_tb_top.sv
module can_mode_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_init = 1'b0, req_sleep = 1'b1, auto_wake_en = 1'b0, auto_busoff_en = 1'b0;
    logic wkui_clr = 1'b0, rx_bit = 1'b1, bit_stb = 1'b0;
    logic bus_busy = 1'b0, frame_done = 1'b0, busoff_enter = 1'b0;
    logic [3:0] mode;
    logic inak, slak, wkui, status_irq, sleep_hw_clr;

    int n_tests = 0, n_fail = 0, cyc_cnt = 0;
    string phase = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    can_mode_seq dut_i (
        .clk(clk), .rst(rst), .req_init(req_init), .req_sleep(req_sleep),
        .auto_wake_en(auto_wake_en), .auto_busoff_en(auto_busoff_en),
        .wkui_clr(wkui_clr), .rx_bit(rx_bit), .bit_stb(bit_stb),
        .bus_busy(bus_busy), .frame_done(frame_done), .busoff_enter(busoff_enter),
        .mode(mode), .inak(inak), .slak(slak), .wkui(wkui),
        .status_irq(status_irq), .sleep_hw_clr(sleep_hw_clr)
    );

    // behavioural reference: 0 sleep, 1 init, 2 normal, 3 bus-off
    int m_state = 0, m_run = 0, m_runs = 0;
    bit m_prev = 1'b1, m_wkui = 1'b0, m_irq = 1'b0, m_clr = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_run = 0; m_runs = 0; m_prev = 1'b1;
            m_wkui = 1'b0; m_irq = 1'b0; m_clr = 1'b0;
        end else begin
            int  nxt;
            bit  wake, refuse, sof, idle, sleep_go;
            nxt = m_state; wake = 0; refuse = 0;
            sof = bit_stb && m_prev && !rx_bit;
            idle = !bus_busy || frame_done;
            sleep_go = req_sleep && !m_clr;
            if (m_state == 0) begin
                if (auto_wake_en && sof) begin nxt = 1; wake = 1; end
                else if (!req_sleep) nxt = 1;
            end else if (m_state == 1) begin
                if (sleep_go) nxt = 0;
                else if (!req_init && m_run == 11) nxt = 2;
            end else if (m_state == 2) begin
                if (busoff_enter) nxt = 3;
                else if (req_init && idle) nxt = 1;
                else if (sleep_go) begin
                    if (auto_wake_en && bus_busy) refuse = 1;
                    else if (idle) nxt = 0;
                end
            end else begin
                if (req_init) nxt = 1;
                else if (auto_busoff_en && m_runs == 128) nxt = 2;
            end
            // run counters use the mode before this edge
            if (m_state == 1 && !req_init) begin
                if (bit_stb) m_run = !rx_bit ? 0 : (m_run < 11 ? m_run + 1 : m_run);
            end else if (m_state == 3) begin
                if (bit_stb) begin
                    if (!rx_bit) m_run = 0;
                    else if (m_run == 10) begin m_run = 0; if (m_runs < 128) m_runs++; end
                    else m_run++;
                end
            end else m_run = 0;
            if (m_state != 3) m_runs = 0;
            if (bit_stb) m_prev = rx_bit;
            m_irq = (wake || refuse) && !m_wkui;
            if (wake || refuse) m_wkui = 1; else if (wkui_clr) m_wkui = 0;
            m_clr = wake || refuse;
            m_state = nxt;
        end
    end

    task automatic check1(string what, logic [3:0] act, logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check1("mode", mode, 4'(1 << m_state));
            check1("inak", {3'b0, inak}, {3'b0, m_state == 1});
            check1("slak", {3'b0, slak}, {3'b0, m_state == 0});
            check1("wkui", {3'b0, wkui}, {3'b0, m_wkui});
            check1("status_irq", {3'b0, status_irq}, {3'b0, m_irq});
            check1("sleep_hw_clr", {3'b0, sleep_hw_clr}, {3'b0, m_clr});
        end
    end

    // one cycle; the register model drops the sleep request on a hardware clear
    task automatic tick();
        @(negedge clk);
        if (sleep_hw_clr) req_sleep = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic send_bit(logic v);
        rx_bit = v; bit_stb = 1'b1;
        tick();
        bit_stb = 1'b0;
        tick();
    endtask

    task automatic send_run(logic v, int n);
        for (int i = 0; i < n; i++) send_bit(v);
    endtask

    task automatic expect_mode(string tag, logic [3:0] exp);
        n_tests++;
        if (mode !== exp) begin
            n_fail++;
            $display("FAIL %s directed mode actual=%b expected=%b", tag, mode, exp);
        end
    endtask

    initial begin
        ticks(3);
        rst = 1'b0;
        tick();
        expect_mode("R1", 4'b0001);

        phase = "R6"; req_sleep = 1'b0; ticks(2);
        expect_mode("R6", 4'b0010);
        phase = "R4";
        send_run(1'b1, 6); send_bit(1'b0); send_run(1'b1, 10);
        expect_mode("R4", 4'b0010);
        send_bit(1'b1); tick();
        expect_mode("R4", 4'b0100);

        phase = "R3"; bus_busy = 1'b1; req_init = 1'b1; ticks(6);
        expect_mode("R3", 4'b0100);
        frame_done = 1'b1; tick(); frame_done = 1'b0; bus_busy = 1'b0;
        expect_mode("R3", 4'b0010);
        req_init = 1'b0; send_run(1'b1, 12); tick();
        expect_mode("R4", 4'b0100);

        phase = "R5"; bus_busy = 1'b1; req_sleep = 1'b1; ticks(5);
        expect_mode("R5", 4'b0100);
        bus_busy = 1'b0; ticks(2);
        expect_mode("R5", 4'b0001);

        phase = "R7"; auto_wake_en = 1'b1; send_run(1'b1, 3); send_bit(1'b0);
        expect_mode("R7", 4'b0010);
        send_run(1'b1, 12); tick();
        expect_mode("R7", 4'b0100);

        phase = "R9"; ticks(8);
        wkui_clr = 1'b1; tick(); wkui_clr = 1'b0; ticks(2);

        phase = "R8"; bus_busy = 1'b1; req_sleep = 1'b1; ticks(6);
        expect_mode("R8", 4'b0100);
        bus_busy = 1'b0; wkui_clr = 1'b1; tick(); wkui_clr = 1'b0; ticks(2);
        phase = "R10"; bus_busy = 1'b1; req_sleep = 1'b1; ticks(4); bus_busy = 1'b0;

        phase = "R11"; auto_wake_en = 1'b0; auto_busoff_en = 1'b1;
        busoff_enter = 1'b1; tick(); busoff_enter = 1'b0;
        expect_mode("R11", 4'b1000);
        send_run(1'b1, 5); send_bit(1'b0);
        send_run(1'b1, 128 * 11 - 1);
        expect_mode("R11", 4'b1000);
        send_bit(1'b1); tick();
        expect_mode("R11", 4'b0100);

        phase = "R12"; auto_busoff_en = 1'b0;
        busoff_enter = 1'b1; tick(); busoff_enter = 1'b0;
        send_run(1'b1, 128 * 11 + 40);
        expect_mode("R12", 4'b1000);
        req_init = 1'b1; tick();
        expect_mode("R12", 4'b0010);
        ticks(3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000 && !done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule